// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block decides which operating mode a small microcontroller core is in and drives the clock, oscillator and reset controls that follow from it. There are three modes. In active mode the CPU runs. In standby the CPU instruction clock is gated off, while the oscillator and the peripheral clock (watchdog, interrupt logic, timer) keep running. In sleep the oscillator is stopped. A fourth, transient phase covers the wake-up from sleep. In that phase the core is held in reset until the oscillator has started.

Software enters standby with a halt strobe. To enter sleep it writes a two-bit control register. The sleep bit takes effect only if the unlock (mask) bit was already 1 before that write. The unlock bit survives a wake-up from sleep, so after a reset software can tell a cold power-up (mask 0) from a wake from sleep (mask 1). Only the external reset pin can end sleep, and the pin must stay high for a programmable number of cycles. The oscillator is modelled by a ready input.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) the block is in active mode (`mode_o` = 0; the other codes are 1 standby, 2 sleep, 3 wake-up). The CPU, peripheral and oscillator enables are 1, `core_rst_o` and `strobe_o` are 0, and `reg_rdata_o` reads 0 (bit 0 = mask, bit 1 = sleep).
- R2: A halt strobe in active mode moves the block to standby from the next cycle. In standby `cpu_clk_en_o` is 0 and `per_clk_en_o` and `osc_en_o` stay 1. `cpu_clk_en_o` is 0 in every mode other than active.
- R3: In standby, any bit of `irq_i` high at a clock edge returns the block to active mode on the next cycle.
- R4: `ext_rst_i` high in active or standby mode gives active mode on the next cycle, with `core_rst_o` and `strobe_o` high for exactly that one cycle. In the same cycle the reset wins over halt, interrupts and register writes; the register write is discarded.
- R5: A register write in active mode loads the mask from bit 0. The sleep bit (bit 1) is taken only if the mask was already 1 before the write; otherwise it is ignored. A write that enters sleep leaves the mask at 1.
- R6: In sleep, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are 0, `core_rst_o` is 1, and the sleep bit reads 1. Interrupts, halt and register writes have no effect.
- R7: Sleep ends only after `ext_rst_i` has been high for RST_MIN_CYC consecutive clock edges. A shorter pulse is discarded and the count starts again.
- R8: The wake-up phase holds `core_rst_o` and `strobe_o` high with `osc_en_o` at 1. It lasts at least STARTUP_CYC cycles and until `osc_ready_i` is high, and then returns to active mode.
- R9: Wake-up clears the sleep bit and keeps the mask at 1.
- R10: A sleep write that is taken wins over a halt strobe in the same cycle.
- R11: Register writes outside active mode are ignored. The read-back value is valid in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on control clock |
| por_n | input | 1 | asynchronous power-on reset, active low |
| halt_i | input | 1 | halt strobe from the CPU |
| reg_wr_i | input | 1 | control register write strobe |
| reg_wdata_i | input | 2 | write data: bit 0 mask, bit 1 sleep |
| ext_rst_i | input | 1 | external reset pin, active high |
| irq_i | input | IRQ_W | enabled interrupt requests |
| osc_ready_i | input | 1 | oscillator reports a stable output |
| cpu_clk_en_o | output | 1 | CPU instruction clock enable |
| per_clk_en_o | output | 1 | peripheral clock enable |
| osc_en_o | output | 1 | oscillator enable |
| core_rst_o | output | 1 | internal reset for the core |
| strobe_o | output | 1 | strobe / reset status output |
| reg_rdata_o | output | 2 | read-back: bit 0 mask, bit 1 sleep |
| mode_o | output | 2 | current mode code |

## Verification
Two pairs of events can fall in the same cycle. In standby, the external reset can coincide with an interrupt request. In active mode, a sleep or unlock write can coincide with a halt strobe or with the reset pin. The bench drives each pair on the same negative edge. A behavioural model resolves them by the stated priorities (reset over write, sleep over halt), and it is compared with the mode, the enables and the read-back on every following cycle. Reset pulses one cycle shorter than the filter length, and oscillator-ready arriving both before and after the minimum start-up wait, are also provoked.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MD_ACTIVE  = 2'd0,
    MD_STANDBY = 2'd1,
    MD_SLEEP   = 2'd2,
    MD_WAKE    = 2'd3
  } pwr_mode_e;

  localparam int MASK_BIT  = 0;
  localparam int SLEEP_BIT = 1;

  // width of a counter that must reach lim-1
  function automatic int cnt_width(input int lim);
    return (lim > 2) ? $clog2(lim) : 1;
  endfunction

  // next mode from current mode and qualified events, priority encoded
  function automatic pwr_mode_e next_mode(
    input pwr_mode_e cur,
    input logic      pin_rst,
    input logic      sleep_go,
    input logic      halt,
    input logic      irq_any,
    input logic      pin_wake,
    input logic      osc_done
  );
    pwr_mode_e n;
    n = cur;
    unique case (cur)
      MD_ACTIVE: begin
        if (pin_rst)       n = MD_ACTIVE;
        else if (sleep_go) n = MD_SLEEP;
        else if (halt)     n = MD_STANDBY;
      end
      MD_STANDBY: if (pin_rst || irq_any) n = MD_ACTIVE;
      MD_SLEEP:   if (pin_wake)           n = MD_WAKE;
      MD_WAKE:    if (osc_done)           n = MD_ACTIVE;
      default:    n = MD_ACTIVE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic arm,
  input  logic level,
  output logic qualified
);
  localparam int CW = pwr_mode_pkg::cnt_width(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt_q <= '0;
    else if (!arm || !level)   cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign qualified = arm && level && (cnt_q == LAST);
endmodule

// File: rtl/pwr_startup_timer.sv
module pwr_startup_timer #(
  parameter int MIN_CYC = 6
) (
  input  logic clk,
  input  logic por_n,
  input  logic arm,
  input  logic osc_ready,
  output logic done
);
  localparam int CW = pwr_mode_pkg::cnt_width(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             cnt_q <= '0;
    else if (!arm)          cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = arm && osc_ready && (cnt_q == LAST);
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [1:0] wdata,
  input  logic       wake_start,
  output logic       sleep_accept,
  output logic [1:0] rdata
);
  import pwr_mode_pkg::*;

  logic mask_q, sleep_q;

  assign sleep_accept = wr_en && wdata[SLEEP_BIT] && mask_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mask_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      if (sleep_accept)    sleep_q <= 1'b1;
      else if (wake_start) sleep_q <= 1'b0;
      if (wr_en && !sleep_accept) mask_q <= wdata[MASK_BIT];
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[MASK_BIT]  = mask_q;
    rdata[SLEEP_BIT] = sleep_q;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int IRQ_W       = 8,
  parameter int RST_MIN_CYC = 4,
  parameter int STARTUP_CYC = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             halt_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_wdata_i,
  input  logic             ext_rst_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic             osc_ready_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             core_rst_o,
  output logic             strobe_o,
  output logic [1:0]       reg_rdata_o,
  output logic [1:0]       mode_o
);
  import pwr_mode_pkg::*;

  pwr_mode_e mode_q, mode_d;
  logic      pulse_q, pulse_d;

  // named internal events
  logic in_active, in_standby, in_sleep, in_wake;
  logic pin_rst;
  logic wr_en;
  logic sleep_accept;
  logic pin_wake;
  logic osc_done;
  logic wake_start;

  assign in_active  = (mode_q == MD_ACTIVE);
  assign in_standby = (mode_q == MD_STANDBY);
  assign in_sleep   = (mode_q == MD_SLEEP);
  assign in_wake    = (mode_q == MD_WAKE);

  assign pin_rst    = ext_rst_i && (in_active || in_standby);
  assign wr_en      = reg_wr_i && in_active && !ext_rst_i;
  assign wake_start = pin_wake;

  pwr_ctrl_regs u_regs (
    .clk          (clk),
    .por_n        (por_n),
    .wr_en        (wr_en),
    .wdata        (reg_wdata_i),
    .wake_start   (wake_start),
    .sleep_accept (sleep_accept),
    .rdata        (reg_rdata_o)
  );

  pwr_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_filt (
    .clk       (clk),
    .por_n     (por_n),
    .arm       (in_sleep),
    .level     (ext_rst_i),
    .qualified (pin_wake)
  );

  pwr_startup_timer #(.MIN_CYC(STARTUP_CYC)) u_start (
    .clk       (clk),
    .por_n     (por_n),
    .arm       (in_wake),
    .osc_ready (osc_ready_i),
    .done      (osc_done)
  );

  always_comb begin
    mode_d  = next_mode(mode_q, pin_rst, sleep_accept, halt_i, |irq_i,
                        pin_wake, osc_done);
    pulse_d = pin_rst;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q  <= MD_ACTIVE;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  assign cpu_clk_en_o = in_active && !pulse_q;
  assign per_clk_en_o = in_active || in_standby;
  assign osc_en_o     = !in_sleep;
  assign core_rst_o   = pulse_q || in_sleep || in_wake;
  assign strobe_o     = pulse_q || in_wake;
  assign mode_o       = mode_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             halt_i,
  input logic             ext_rst_i,
  input logic [IRQ_W-1:0] irq_i,
  input logic             osc_ready_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_wdata_i,
  input logic [1:0]       reg_rdata_o,
  input logic [1:0]       mode_o,
  input logic             cpu_clk_en_o,
  input logic             osc_en_o,
  input logic             core_rst_o,
  input logic             sleep_accept,
  input logic             wake_start
);
  import pwr_mode_pkg::*;

  AST_CPU_STOPPED: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o != MD_ACTIVE) |-> !cpu_clk_en_o); // R2

  AST_HALT_TO_STANDBY: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_ACTIVE && halt_i && !ext_rst_i && !sleep_accept) |=> (mode_o == MD_STANDBY)); // R2

  AST_IRQ_WAKES_STANDBY: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_STANDBY && (|irq_i)) |=> (mode_o == MD_ACTIVE)); // R3

  AST_PIN_RESET_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    ((mode_o == MD_ACTIVE || mode_o == MD_STANDBY) && ext_rst_i) |=> (mode_o == MD_ACTIVE && core_rst_o)); // R4

  AST_SLEEP_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (reg_wr_i && reg_wdata_i[SLEEP_BIT] && !reg_rdata_o[MASK_BIT]) |-> !sleep_accept); // R5

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    sleep_accept |=> (mode_o == MD_SLEEP && reg_rdata_o == 2'b11)); // R5

  AST_SLEEP_OSC_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_SLEEP) |-> (!osc_en_o && core_rst_o)); // R6

  AST_SLEEP_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_SLEEP && !ext_rst_i) |=> (mode_o == MD_SLEEP)); // R7

  AST_WAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_WAKE && !osc_ready_i) |=> (mode_o == MD_WAKE)); // R8

  AST_WAKE_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    wake_start |=> (mode_o == MD_WAKE && reg_rdata_o == 2'b01)); // R9

  AST_WAKE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == MD_WAKE) |-> (reg_rdata_o == 2'b01)); // R9
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .halt_i       (halt_i),
  .ext_rst_i    (ext_rst_i),
  .irq_i        (irq_i),
  .osc_ready_i  (osc_ready_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .mode_o       (mode_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .osc_en_o     (osc_en_o),
  .core_rst_o   (core_rst_o),
  .sleep_accept (sleep_accept),
  .wake_start   (wake_start)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int IRQ_W = 8;
  localparam int RMIN  = 4;
  localparam int SMIN  = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             por_n = 1'b0;
  logic             halt_i = 1'b0, reg_wr_i = 1'b0, ext_rst_i = 1'b0, osc_ready_i = 1'b0;
  logic [1:0]       reg_wdata_i = '0;
  logic [IRQ_W-1:0] irq_i = '0;
  logic cpu_clk_en_o, per_clk_en_o, osc_en_o, core_rst_o, strobe_o;
  logic [1:0] reg_rdata_o, mode_o;

  pwr_mode_ctrl #(.IRQ_W(IRQ_W), .RST_MIN_CYC(RMIN), .STARTUP_CYC(SMIN)) u_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .halt_i(halt_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .ext_rst_i(ext_rst_i), .irq_i(irq_i),
    .osc_ready_i(osc_ready_i), .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o), .osc_en_o(osc_en_o), .core_rst_o(core_rst_o),
    .strobe_o(strobe_o), .reg_rdata_o(reg_rdata_o), .mode_o(mode_o)
  );

  int n_cmp = 0, n_bad = 0;

  // behavioural model: 0 active, 1 standby, 2 sleep, 3 wake-up
  int m_st = 0, m_mask = 0, m_sleep = 0, m_pulse = 0, m_run = 0, m_wait = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st = 0; m_mask = 0; m_sleep = 0; m_pulse = 0; m_run = 0; m_wait = 0;
    end else begin
      m_pulse = 0;
      case (m_st)
        0: begin
          if (ext_rst_i) m_pulse = 1;
          else if (reg_wr_i && reg_wdata_i[1] && m_mask == 1) begin
            m_st = 2; m_sleep = 1; m_run = 0;
          end else begin
            if (reg_wr_i) m_mask = reg_wdata_i[0];
            if (halt_i) m_st = 1;
          end
        end
        1: begin
          if (ext_rst_i) begin m_st = 0; m_pulse = 1; end
          else if (irq_i != 0) m_st = 0;
        end
        2: begin
          if (ext_rst_i) m_run++; else m_run = 0;
          if (m_run >= RMIN) begin m_st = 3; m_sleep = 0; m_wait = 0; end
        end
        default: begin
          m_wait++;
          if (m_wait >= SMIN && osc_ready_i) m_st = 0;
        end
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (por_n) begin
    chk("R1 mode_o", 32'(mode_o), m_st);
    chk("R2 cpu_clk_en_o", 32'(cpu_clk_en_o), 32'(m_st == 0 && m_pulse == 0));
    chk("R6 per_clk_en_o", 32'(per_clk_en_o), 32'(m_st <= 1));
    chk("R6 osc_en_o", 32'(osc_en_o), 32'(m_st != 2));
    chk("R4 core_rst_o", 32'(core_rst_o), 32'(m_pulse == 1 || m_st >= 2));
    chk("R8 strobe_o", 32'(strobe_o), 32'(m_pulse == 1 || m_st == 3));
    chk("R5 reg_rdata_o", 32'(reg_rdata_o), 32'(m_sleep * 2 + m_mask));
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(string tag, int md, int rd);
    chk(tag, 32'(mode_o), md);
    chk(tag, 32'(reg_rdata_o), rd);
  endtask

  task automatic wr(logic [1:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    por_n = 1'b1;
    step(1);
    expect_st("R1 reset state", 0, 0);
    chk("R1 strobe", 32'(strobe_o), 0);

    halt_i = 1; step(1); halt_i = 0;
    expect_st("R2 standby", 1, 0);
    step(3);
    expect_st("R2 standby holds", 1, 0);

    wr(2'b01); step(1); reg_wr_i = 0;
    expect_st("R11 write in standby ignored", 1, 0);

    irq_i = 8'h10; step(1); irq_i = '0;
    expect_st("R3 irq wakes standby", 0, 0);

    halt_i = 1; step(1); halt_i = 0;
    ext_rst_i = 1; irq_i = 8'h01; step(1); ext_rst_i = 0; irq_i = '0;
    expect_st("R4 reset with irq", 0, 0);
    chk("R4 core reset pulse", 32'(core_rst_o), 1);
    step(1);
    chk("R4 pulse lasts one cycle", 32'(core_rst_o), 0);

    ext_rst_i = 1; halt_i = 1; wr(2'b01); step(1);
    ext_rst_i = 0; halt_i = 0; reg_wr_i = 0;
    expect_st("R4 reset beats halt and write", 0, 0);
    step(1);

    wr(2'b11); step(1); reg_wr_i = 0;
    expect_st("R5 locked sleep write ignored, mask set", 0, 1);

    wr(2'b10); halt_i = 1; step(1); reg_wr_i = 0; halt_i = 0;
    expect_st("R10 sleep beats halt", 2, 3);
    chk("R6 oscillator off", 32'(osc_en_o), 0);

    irq_i = 8'hFF; halt_i = 1; wr(2'b00); step(2);
    irq_i = '0; halt_i = 0; reg_wr_i = 0;
    expect_st("R6 sleep ignores irq halt write", 2, 3);

    ext_rst_i = 1; step(RMIN - 1); ext_rst_i = 0; step(1);
    expect_st("R7 short pulse discarded", 2, 3);
    ext_rst_i = 1; step(RMIN - 1);
    expect_st("R7 not yet qualified", 2, 3);
    step(1); ext_rst_i = 0;
    expect_st("R8 wake-up phase", 3, 1);
    chk("R8 strobe high", 32'(strobe_o), 1);

    osc_ready_i = 0; step(SMIN + 3);
    expect_st("R8 waits for oscillator", 3, 1);
    osc_ready_i = 1; step(1);
    expect_st("R9 active, mask kept", 0, 1);

    wr(2'b11); step(1); reg_wr_i = 0;
    expect_st("R5 sleep accepted", 2, 3);
    ext_rst_i = 1; step(RMIN); ext_rst_i = 0;
    step(SMIN - 1);
    expect_st("R8 minimum wait", 3, 1);
    step(1);
    expect_st("R8 released", 0, 1);

    wr(2'b00); step(1); reg_wr_i = 0;
    expect_st("R5 mask cleared", 0, 0);
    wr(2'b10); step(1); reg_wr_i = 0;
    expect_st("R5 sleep relocked", 0, 0);
    step(2);
    summary();
  end
endmodule